// File: doc/BRIEF.md
# Per-Select SPI Master

This block is a serial peripheral interface master that talks to up to four peripherals. Each peripheral has its own chip-select line and its own stored setting, made of a clock divider, a word length from 8 to 16 bits, a clock polarity and a clock phase. When a transfer starts, the block copies the setting of the addressed peripheral into its active state and asserts that peripheral's active-low select. It then shifts one word out on MOSI, most significant bit first, and shifts one word in from MISO. Two slow and fast peripherals can follow each other without a stray clock pulse, and the divider can go down to one.

Software or a sequencer writes through a single-cycle write port. That port reaches four setting slots, a transmit slot that carries the data word and the select index, and a control slot with an enable bit and a reset bit. Received words appear on a read port together with a receive-full flag, which clears when the word is read. A transmit-ready flag shows when the one-word holding slot is free.

Top module: `spi_mcs_master`

## Requirements
- R1: After reset, all chip selects are high, SPCK is 0, tx_ready is 1, rx_full is 0 and busy is 0.
- R2: Addresses 0 to 3 write the setting of select 0 to 3. The fields are bits [7:0] divider, [11:8] length code, [12] CPOL and [13] NCPHA. A transfer uses the setting of the select named in bits [17:16] of the transmit write (address 4), and it drives only that select's cs_n bit low.
- R3: Length code L gives 8+L bits, and codes above 8 give 16 bits. The transmit word sits in the low bits of [15:0] and is sent MSB first. The received word is right-justified in rx_data, with the upper bits at zero.
- R4: Every frame carries exactly two SPCK edges per bit while the select is low, for every divider and length, including divider 1 with odd lengths.
- R5: Each SPCK half period lasts divider system clock cycles. A divider of 0 acts as 1.
- R6: SPCK sits at the CPOL level when the select falls and when it rises. With NCPHA=1 MISO is captured on the leading edge and MOSI changes on the trailing edge. With NCPHA=0 MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R7: The select falls at least one half period before the first SPCK edge and rises at least one half period after the last edge. No SPCK edge occurs while all selects are high, except that the idle level moves to the new CPOL before the select falls.
- R8: A transfer that follows one on a select with a different divider carries the same exact pulse count as any other transfer.
- R9: A transmit write while tx_ready is 0 is ignored. The held word and its select are kept.
- R10: A transfer starts only while the enable bit (control bit 0 at address 5) is 1. A held word waits until the bit is set.
- R11: rx_full goes to 1 when a received word is available. A one-cycle rd_en clears it.
- R12: A single write of control bit 1 returns the block to idle on the next cycle. All selects go high, SPCK goes to 0, the flags and the held word are cleared and enable is cleared. The per-select settings are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write slot: 0-3 setting, 4 transmit, 5 control |
| wr_data | input | 18 | Write data |
| rd_en | input | 1 | Acknowledges the received word |
| rx_data | output | 16 | Last received word, right-justified |
| rx_full | output | 1 | Received word pending |
| tx_ready | output | 1 | Holding slot free |
| busy | output | 1 | Transfer in progress |
| spck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the block with its default parameters: four selects, an 8-bit divider and frames of 8 to 16 bits. With these values the bench reaches every select, every odd length at divider 1, divider 0, and a slow-to-fast pair of selects with CPOL=1 and NCPHA=0. A slave model in the bench reacts to SPCK edges. It counts the edges, times the select lead and trail and the half period, and swaps a word in each direction. These checks are made for both phases and both polarities, for an aborted transfer and for the transfer that follows it.

// File: rtl/spi_mcs_pkg.sv
package spi_mcs_pkg;
  localparam int DIV_W    = 8;
  localparam int LEN_W    = 4;
  localparam int MIN_BITS = 8;
  localparam int MAX_BITS = 16;
  localparam int BITS_W   = $clog2(MAX_BITS + 1);
  localparam int HALF_W   = $clog2(2 * MAX_BITS);
  localparam int CFG_W    = DIV_W + LEN_W + 2;
  localparam int F_LEN    = DIV_W;
  localparam int F_CPOL   = DIV_W + LEN_W;
  localparam int F_NCPHA  = F_CPOL + 1;
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_TX   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd5;

  typedef struct packed {
    logic              ncpha;
    logic              cpol;
    logic [BITS_W-1:0] bits;
    logic [DIV_W-1:0]  div;
  } cs_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LEAD, ST_SHIFT, ST_TRAIL
  } eng_st_t;

  // Divider 0 is not a legal setting and is mapped to 1.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  function automatic logic [BITS_W-1:0] frame_bits(input logic [LEN_W-1:0] c);
    int t;
    t = MIN_BITS + int'(c);
    if (t > MAX_BITS) t = MAX_BITS;
    return BITS_W'(t);
  endfunction

  function automatic cs_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    cs_cfg_t c;
    c.div   = eff_div(w[DIV_W-1:0]);
    c.bits  = frame_bits(w[F_LEN +: LEN_W]);
    c.cpol  = w[F_CPOL];
    c.ncpha = w[F_NCPHA];
    return c;
  endfunction

  // Index of the final half period of a frame: 2*bits-1.
  function automatic logic [HALF_W-1:0] last_half_of(input logic [BITS_W-1:0] b);
    int t;
    t = 2 * int'(b) - 1;
    return HALF_W'(t);
  endfunction

  // Moves a right-justified word so that its MSB sits at the top of the shifter.
  function automatic logic [MAX_BITS-1:0] align_msb(input logic [MAX_BITS-1:0] d,
                                                    input logic [BITS_W-1:0] b);
    return d << (MAX_BITS - int'(b));
  endfunction
endpackage

// File: rtl/spi_mcs_cfg_bank.sv
module spi_mcs_cfg_bank
  import spi_mcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CS_W-1:0]  wr_idx,
  input  logic [CFG_W-1:0] wr_word,
  input  logic [CS_W-1:0]  rd_idx,
  output cs_cfg_t          rd_cfg
);
  localparam cs_cfg_t CFG_RST = '{ncpha: 1'b0, cpol: 1'b0,
                                  bits: BITS_W'(MIN_BITS), div: DIV_W'(1)};

  cs_cfg_t slot_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= CFG_RST;
      end else if (wr_en && wr_idx == CS_W'(g)) begin
        slot_q[g] <= decode_cfg(wr_word);
      end
    end

    a_r5_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q[g].div != '0);
  end

  assign rd_cfg = slot_q[rd_idx];
endmodule

// File: rtl/spi_mcs_half_timer.sv
module spi_mcs_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             fast;
  logic             at_end;

  // Divider 1 bypasses the compare: one edge on every cycle.
  assign fast   = (div == DIV_W'(1));
  assign at_end = (cnt_q == div - DIV_W'(1));
  assign tick   = run && (fast || at_end);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q < div);
endmodule

// File: rtl/spi_mcs_engine.sv
module spi_mcs_engine
  import spi_mcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                start,
  input  cs_cfg_t             start_cfg,
  input  logic [CS_W-1:0]     start_cs,
  input  logic [MAX_BITS-1:0] start_data,
  input  logic                miso,
  output logic                idle,
  output logic                frame_done,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                spck,
  output logic                mosi,
  output logic [NUM_CS-1:0]   cs_n
);
  eng_st_t             st_q;
  cs_cfg_t             act_q;
  logic [CS_W-1:0]     act_cs_q;
  logic [HALF_W-1:0]   half_q;
  logic [MAX_BITS-1:0] tx_sh_q;
  logic [MAX_BITS-1:0] rx_sh_q;
  logic                spck_q;
  logic                mosi_q;
  logic [NUM_CS-1:0]   cs_n_q;
  logic [HALF_W:0]     chk_edges_q;

  logic              tick;
  logic              run;
  logic [HALF_W-1:0] last_half;
  logic [HALF_W-1:0] next_half;
  logic              edge_evt;
  logic              edge_lead;
  logic              capture;
  logic              launch;
  logic              accept;

  assign run       = (st_q == ST_LEAD) || (st_q == ST_SHIFT) || (st_q == ST_TRAIL);
  assign last_half = last_half_of(act_q.bits);
  assign next_half = (st_q == ST_LEAD) ? '0 : half_q + HALF_W'(1);
  assign edge_evt  = tick && ((st_q == ST_LEAD) ||
                              (st_q == ST_SHIFT && half_q != last_half));
  assign frame_done = tick && (st_q == ST_SHIFT) && (half_q == last_half);
  // Even half-period index: the edge leaves the idle level.
  assign edge_lead = ~next_half[0];
  assign capture   = edge_evt && (edge_lead == act_q.ncpha);
  assign launch    = edge_evt && !capture;
  assign accept    = start && (st_q == ST_IDLE);

  spi_mcs_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (act_q.div),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      st_q     <= ST_IDLE;
      act_q    <= '0;
      act_cs_q <= '0;
      half_q   <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      spck_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cs_n_q   <= '1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          act_q    <= start_cfg;
          act_cs_q <= start_cs;
          tx_sh_q  <= align_msb(start_data, start_cfg.bits);
          rx_sh_q  <= '0;
          spck_q   <= start_cfg.cpol;
          st_q     <= ST_SETUP;
        end
        ST_SETUP: begin
          cs_n_q <= ~(NUM_CS'(1) << act_cs_q);
          if (act_q.ncpha) begin
            mosi_q  <= tx_sh_q[MAX_BITS-1];
            tx_sh_q <= tx_sh_q << 1;
          end
          st_q <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          half_q <= '0;
          st_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (half_q == last_half) st_q <= ST_TRAIL;
          else                     half_q <= next_half;
        end
        ST_TRAIL: if (tick) begin
          cs_n_q <= '1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase

      if (edge_evt) spck_q <= ~spck_q;
      if (capture)  rx_sh_q <= {rx_sh_q[MAX_BITS-2:0], miso};
      if (launch) begin
        mosi_q  <= tx_sh_q[MAX_BITS-1];
        tx_sh_q <= tx_sh_q << 1;
      end
    end
  end

  // Edge counter used only by the assertions below.
  always_ff @(posedge clk) begin
    if (!rst_n || accept) chk_edges_q <= '0;
    else if (edge_evt)    chk_edges_q <= chk_edges_q + 1'b1;
  end

  assign idle    = (st_q == ST_IDLE);
  assign rx_word = rx_sh_q;
  assign spck    = spck_q;
  assign mosi    = mosi_q;
  assign cs_n    = cs_n_q;

  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_q));
  a_r4_exact_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> chk_edges_q == {1'b0, last_half} + 1'b1);
  a_r7_no_edge_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> cs_n_q != '1);
  a_r6_level_before_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LEAD) |-> spck_q == act_q.cpol);
  a_r6_level_in_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIL) |-> spck_q == act_q.cpol);
  a_r7_idle_clock_still: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !accept && !soft_rst) |=> $stable(spck_q));
  a_r5_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && act_q.div == DIV_W'(1) && !frame_done && !soft_rst)
      |=> half_q == $past(half_q) + HALF_W'(1));
  a_r12_sw_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st_q == ST_IDLE && cs_n_q == '1 && spck_q == 1'b0));
endmodule

// File: rtl/spi_mcs_master.sv
module spi_mcs_master
  import spi_mcs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int WD_W  = MAX_BITS + CS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WD_W-1:0]     wr_data,
  input  logic                rd_en,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_full,
  output logic                tx_ready,
  output logic                busy,
  output logic                spck,
  output logic                mosi,
  input  logic                miso,
  output logic [NUM_CS-1:0]   cs_n
);
  logic                cfg_we, tx_we, ctrl_we, soft_rst;
  logic                en_q, hold_v_q, rx_full_q;
  logic [MAX_BITS-1:0] hold_data_q, rx_q;
  logic [CS_W-1:0]     hold_cs_q;
  logic                eng_idle, frame_done, start_acc;
  logic [MAX_BITS-1:0] rx_word;
  cs_cfg_t             sel_cfg;

  assign cfg_we    = wr_en && (int'(wr_addr) < NUM_CS);
  assign tx_we     = wr_en && (wr_addr == ADDR_TX);
  assign ctrl_we   = wr_en && (wr_addr == ADDR_CTRL);
  assign soft_rst  = ctrl_we && wr_data[1];
  assign start_acc = en_q && hold_v_q && eng_idle;

  spi_mcs_cfg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (wr_addr[CS_W-1:0]),
    .wr_word(wr_data[CFG_W-1:0]),
    .rd_idx (hold_cs_q),
    .rd_cfg (sel_cfg)
  );

  spi_mcs_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .start     (en_q && hold_v_q),
    .start_cfg (sel_cfg),
    .start_cs  (hold_cs_q),
    .start_data(hold_data_q),
    .miso      (miso),
    .idle      (eng_idle),
    .frame_done(frame_done),
    .rx_word   (rx_word),
    .spck      (spck),
    .mosi      (mosi),
    .cs_n      (cs_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      en_q        <= 1'b0;
      hold_v_q    <= 1'b0;
      hold_data_q <= '0;
      hold_cs_q   <= '0;
      rx_full_q   <= 1'b0;
      rx_q        <= '0;
    end else begin
      if (ctrl_we)   en_q <= wr_data[0];
      if (start_acc) hold_v_q <= 1'b0;
      if (tx_we && !hold_v_q) begin
        hold_v_q    <= 1'b1;
        hold_data_q <= wr_data[MAX_BITS-1:0];
        hold_cs_q   <= wr_data[MAX_BITS +: CS_W];
      end
      if (frame_done) begin
        rx_q      <= rx_word;
        rx_full_q <= 1'b1;
      end else if (rd_en) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign rx_data  = rx_q;
  assign rx_full  = rx_full_q;
  assign tx_ready = !hold_v_q;
  assign busy     = !eng_idle;

  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && hold_v_q && !start_acc) |=> ($stable(hold_data_q) && $stable(hold_cs_q)));
  a_r10_wait_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !en_q) |=> eng_idle);
  a_r11_full_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !soft_rst) |=> rx_full_q);
  a_r12_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rx_full_q && !hold_v_q && !en_q));
endmodule

// File: tb/spi_mcs_master_tb_top.sv
module spi_mcs_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        miso = 1'b0;
  logic [15:0] rx_data;
  logic        rx_full, tx_ready, busy, spck, mosi;
  logic [3:0]  cs_n;
  wire         cs_hi = &cs_n;

  always #10 clk = ~clk;

  spi_mcs_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rx_data(rx_data), .rx_full(rx_full), .tx_ready(tx_ready),
    .busy(busy), .spck(spck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  // {cs[2], div[8], len code[4], cpol, ncpha, tx[16], slave word[16]}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 8'd1, 4'd1, 1'b0, 1'b1, 16'h0155, 16'h00AA},
    {2'd1, 8'd1, 4'd3, 1'b1, 1'b0, 16'h05A5, 16'h03C3},
    {2'd2, 8'd1, 4'd5, 1'b0, 1'b0, 16'h1ABC, 16'h0F0F},
    {2'd3, 8'd1, 4'd7, 1'b1, 1'b1, 16'h7123, 16'h4567},
    {2'd0, 8'd1, 4'd0, 1'b0, 1'b1, 16'h00A5, 16'h003C},
    {2'd1, 8'd3, 4'd8, 1'b0, 1'b1, 16'hBEEF, 16'hCAFE},
    {2'd0, 8'd5, 4'd4, 1'b1, 1'b0, 16'h0ABC, 16'h0123},
    {2'd1, 8'd1, 4'd4, 1'b1, 1'b0, 16'h0FED, 16'h0321},
    {2'd2, 8'd0, 4'd2, 1'b1, 1'b1, 16'h02AA, 16'h0155},
    {2'd3, 8'd2, 4'd6, 1'b0, 1'b0, 16'h3333, 16'h2222}
  };

  // Slave model and monitor state
  logic s_cpol = 1'b0, s_ncpha = 1'b0;
  int   s_bits = 8, s_bit = 0;
  logic [15:0] s_out = '0, s_in = '0;
  int   m_edges = 0, m_fall_t = 0, m_first_t = 0, m_second_t = 0, m_last_t = 0;
  int   m_rise_t = 0, m_falls = 0;
  logic [3:0] m_cs_pat = '1;
  logic m_lvl_fall = 1'b0, m_lvl_rise = 1'b0;
  bit   m_done = 1'b0;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge cs_hi) begin
    m_falls++;
    m_edges = 0; m_fall_t = cyc; m_cs_pat = cs_n; m_lvl_fall = spck;
    s_bit = 0; s_in = '0;
    if (s_ncpha) miso = s_out[s_bits-1];
  end

  always @(posedge cs_hi) begin
    m_rise_t = cyc; m_lvl_rise = spck; m_done = 1'b1;
  end

  always @(spck) begin
    if (cs_hi === 1'b0) begin
      m_edges++;
      if (m_edges == 1) m_first_t = cyc;
      if (m_edges == 2) m_second_t = cyc;
      m_last_t = cyc;
      if (spck !== s_cpol) begin            // leading edge
        if (s_ncpha) s_in = {s_in[14:0], mosi};
        else if (s_bit < s_bits) miso = s_out[s_bits-1-s_bit];
      end else begin                        // trailing edge
        if (!s_ncpha) s_in = {s_in[14:0], mosi};
        s_bit++;
        if (s_ncpha && s_bit < s_bits) miso = s_out[s_bits-1-s_bit];
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_err++;
    $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [17:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int bits_of(input logic [3:0] c);
    return (c > 8) ? 16 : 8 + int'(c);
  endfunction

  function automatic int div_of(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic set_slave(input logic [3:0] len, input logic cpol, input logic ncpha,
                           input logic [15:0] word);
    s_bits = bits_of(len); s_cpol = cpol; s_ncpha = ncpha;
    s_out = word & 16'((32'd1 << s_bits) - 1);
  endtask

  task automatic wait_frame();
    while (!(m_done && !busy)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] cs, input logic [7:0] dv, input logic [3:0] len,
                      input logic cpol, input logic ncpha, input logic [15:0] tx,
                      input logic [15:0] sw, input bit do_cfg, input string tag);
    int b, d;
    logic [15:0] mask;
    b = bits_of(len); d = div_of(dv);
    mask = 16'((32'd1 << b) - 1);
    set_slave(len, cpol, ncpha, sw);
    if (do_cfg) wr({1'b0, cs}, {4'b0, ncpha, cpol, len, dv});
    m_done = 1'b0;
    wr(3'd4, {cs, tx});
    wait_frame();
    chk(m_cs_pat == ~(4'b1 << cs), {tag, " R2 select"}, m_cs_pat, ~(4'b1 << cs));
    chk(m_edges == 2*b, {tag, " R4 R8 edges"}, m_edges, 2*b);
    chk(m_second_t - m_first_t == d, {tag, " R5 half period"}, m_second_t - m_first_t, d);
    chk(m_first_t - m_fall_t >= d, {tag, " R7 lead"}, m_first_t - m_fall_t, d);
    chk(m_rise_t - m_last_t >= d, {tag, " R7 trail"}, m_rise_t - m_last_t, d);
    chk(m_lvl_fall == cpol && m_lvl_rise == cpol, {tag, " R6 idle level"},
        {m_lvl_fall, m_lvl_rise}, {cpol, cpol});
    chk(s_in == (tx & mask), {tag, " R3 mosi word"}, s_in, tx & mask);
    chk(rx_data == (sw & mask), {tag, " R3 R6 rx word"}, rx_data, sw & mask);
    chk(rx_full == 1'b1, {tag, " R11 full set"}, rx_full, 1);
    rd();
    chk(rx_full == 1'b0, {tag, " R11 full cleared"}, rx_full, 0);
  endtask

  initial begin
    int falls0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF && spck == 1'b0, "R1 lines", {cs_n, spck}, 5'b11110);
    chk(tx_ready && !rx_full && !busy, "R1 flags", {tx_ready, rx_full, busy}, 3'b100);

    wr(3'd5, 18'd1);
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      xfer(v[47:46], v[45:38], v[37:34], v[33], v[32], v[31:16], v[15:0], 1'b1,
           $sformatf("vec%0d", i));
    end

    // R10: held word waits for enable; R9: second write ignored
    wr(3'd5, 18'd0);
    wr(3'd2, {4'b0, 1'b0, 1'b1, 4'd0, 8'd2});
    set_slave(4'd0, 1'b1, 1'b0, 16'h0081);
    falls0 = m_falls;
    m_done = 1'b0;
    wr(3'd4, {2'd2, 16'h00C3});
    repeat (30) @(negedge clk);
    chk(m_falls == falls0 && !busy, "R10 no start while disabled", m_falls, falls0);
    chk(tx_ready == 1'b0, "R9 holding full", tx_ready, 0);
    wr(3'd4, {2'd1, 16'h0011});
    chk(tx_ready == 1'b0 && !busy, "R9 extra write ignored", tx_ready, 0);
    wr(3'd5, 18'd1);
    wait_frame();
    chk(s_in == 16'h00C3, "R9 R10 first word sent", s_in, 16'h00C3);
    chk(m_cs_pat == 4'b1011, "R9 held select kept", m_cs_pat, 4'b1011);
    chk(rx_data == 16'h0081, "R6 rx cpol1 ncpha0", rx_data, 16'h0081);
    rd();
    repeat (40) @(negedge clk);
    chk(m_falls == falls0 + 1 && tx_ready, "R9 single transfer", m_falls, falls0 + 1);

    // R12: single-write software reset in the middle of a slow frame
    wr(3'd0, {4'b0, 1'b0, 1'b1, 4'd8, 8'd20});
    set_slave(4'd8, 1'b1, 1'b0, 16'h1234);
    wr(3'd4, {2'd0, 16'hFFFF});
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R12 frame running", busy, 1);
    wr(3'd5, 18'd2);
    chk(cs_n == 4'hF && spck == 1'b0 && !busy, "R12 idle after reset",
        {cs_n, spck, busy}, 6'b111100);
    chk(tx_ready && !rx_full, "R12 flags cleared", {tx_ready, rx_full}, 2'b10);
    // enable was cleared: a new word must wait
    falls0 = m_falls;
    set_slave(4'd8, 1'b1, 1'b0, 16'h5AC3);
    m_done = 1'b0;
    wr(3'd4, {2'd0, 16'h9D2E});
    repeat (20) @(negedge clk);
    chk(m_falls == falls0, "R12 enable cleared", m_falls, falls0);
    wr(3'd5, 18'd1);
    wait_frame();
    chk(m_edges == 32, "R12 R4 full frame after reset", m_edges, 32);
    chk(m_first_t - m_fall_t >= 20, "R12 R7 select before clock", m_first_t - m_fall_t, 20);
    chk(m_second_t - m_first_t == 20, "R12 setting kept", m_second_t - m_first_t, 20);
    chk(s_in == 16'h9D2E && rx_data == 16'h5AC3, "R12 R3 data after reset", s_in, 16'h9D2E);
    rd();

    // R3: length code above 8 clamps to 16 bits
    xfer(2'd3, 8'd1, 4'd15, 1'b0, 1'b1, 16'hA55A, 16'h3CC3, 1'b1, "clamp R3");

    summary();
    $finish;
  end
endmodule